// File: doc/BRIEF.md
# Exception Return Status Unit

This block keeps the processor's 32-bit condition and status word, together with the active stack pointer, a user stack pointer and a saved kernel stack pointer. A one-cycle return strobe restores the status that was stacked when the exception was taken, in a single clock edge. The bits of the nested status field move down by a fixed shift. The two top mode bits are kept. If the restored value selects user mode, the active and kernel stack pointers are exchanged for the user copy. The pending-store flag is set unless the restored status carries the R flag.

A separate store-check strobe asks whether a conditional store may complete. The block answers one cycle later on a fail pin, which is raised when the pending-store flag was set. Software-side writes of the status word and of each stack register come in through plain write-enable and data pins. None of the pins carries a data stream, so the block has no valid/ready handshake and never applies back-pressure: every strobe is taken in the cycle it is high.

Flag positions used throughout (parameters, defaults shown): U (user mode) = bit 8, P (pending store) = bit 7, R = bit 9.

Top module: `rfe_status_unit`

## Requirements
- R1: A return strobe loads the status with the old bits 31:30 unchanged, bits 29:28 cleared, and old bits 27:10 placed in bits 17:0, so that bits 27:18 become zero. This happens before the P update of R4.
- R2: When bit 8 (U) of the shifted value is 1, the same edge copies the active SP into the kernel SP and loads the active SP from the user SP.
- R3: When bit 8 of the shifted value is 0, a return leaves the active SP and the kernel SP unchanged.
- R4: After a return, bit 7 (P) is 1 when bit 9 (R) of the shifted value is 0. Otherwise P keeps the shifted value's bit 7.
- R5: The cycle after a store-check strobe, st_fail_o is 1 if P was 1 when the strobe was taken, and 0 if it was not. In a cycle after no strobe, st_fail_o is 0.
- R6: Reset clears the status, the active, user and kernel stack pointers, and st_fail_o.
- R7: When no return is taken, each write enable loads its register from its data pin on the next edge: status, active SP, user SP, kernel SP.
- R8: In a cycle with a return strobe, all four write enables are ignored.
- R9: A store check taken in the same cycle as a return uses the P value from before the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfe_i | input | 1 | Return-from-exception strobe |
| st_chk_i | input | 1 | Conditional-store check strobe |
| stat_we_i | input | 1 | Status write enable |
| stat_wdata_i | input | 32 | Status write data |
| sp_we_i | input | 1 | Active SP write enable |
| sp_wdata_i | input | 32 | Active SP write data |
| usp_we_i | input | 1 | User SP write enable |
| usp_wdata_i | input | 32 | User SP write data |
| ksp_we_i | input | 1 | Kernel SP write enable |
| ksp_wdata_i | input | 32 | Kernel SP write data |
| stat_o | output | 32 | Current status word |
| sp_o | output | 32 | Active stack pointer |
| ksp_o | output | 32 | Saved kernel stack pointer |
| st_fail_o | output | 1 | Conditional store failed (one cycle after check) |

## Verification
The assertions check on every cycle that a return keeps the top mode bits and clears the gap bits, and that it never leaves both R and P clear. They also check that the stack pointers swap or hold according to the shifted U bit, and that the fail pin follows the store check and P. The numeric result of the shift, the ignored writes in a return cycle, and the ordering of a store check against a return that happens in the same cycle are shown only by the bench's scenarios. There, a reference model predicts every register after each operation.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_KEEP_W = 2;
  localparam int unsigned DEF_GAP_W  = 2;
  localparam int unsigned DEF_SHIFT  = 10;
  localparam int unsigned DEF_U_BIT  = 8;
  localparam int unsigned DEF_P_BIT  = 7;
  localparam int unsigned DEF_R_BIT  = 9;
endpackage

// File: rtl/rfe_shift.sv
module rfe_shift #(
  parameter int unsigned DATA_W = rfe_pkg::DEF_DATA_W,
  parameter int unsigned KEEP_W = rfe_pkg::DEF_KEEP_W,
  parameter int unsigned GAP_W  = rfe_pkg::DEF_GAP_W,
  parameter int unsigned SHIFT  = rfe_pkg::DEF_SHIFT,
  parameter int unsigned U_BIT  = rfe_pkg::DEF_U_BIT,
  parameter int unsigned P_BIT  = rfe_pkg::DEF_P_BIT,
  parameter int unsigned R_BIT  = rfe_pkg::DEF_R_BIT
) (
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] stat_next_o,
  output logic              user_o
);
  localparam int unsigned LOW_W = DATA_W - KEEP_W - GAP_W;

  logic [LOW_W-1:0]  low_sh;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    low_sh  = stat_i[LOW_W-1:0] >> SHIFT;
    shifted = {stat_i[DATA_W-1 -: KEEP_W], {GAP_W{1'b0}}, low_sh};
    user_o  = shifted[U_BIT];
    stat_next_o = shifted;
    if (!shifted[R_BIT]) stat_next_o[P_BIT] = 1'b1;
  end
endmodule

// File: rtl/rfe_stack.sv
module rfe_stack #(
  parameter int unsigned DATA_W = rfe_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfe_i,
  input  logic              user_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_wdata_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] usp_wdata_i,
  input  logic              ksp_we_i,
  input  logic [DATA_W-1:0] ksp_wdata_i,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] ksp_o
);
  logic [DATA_W-1:0] sp_q, usp_q, ksp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      usp_q <= '0;
      ksp_q <= '0;
    end else if (rfe_i) begin
      if (user_i) begin
        ksp_q <= sp_q;
        sp_q  <= usp_q;
      end
    end else begin
      if (sp_we_i)  sp_q  <= sp_wdata_i;
      if (usp_we_i) usp_q <= usp_wdata_i;
      if (ksp_we_i) ksp_q <= ksp_wdata_i;
    end
  end

  assign sp_o  = sp_q;
  assign ksp_o = ksp_q;

  p_swap_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_i && user_i |=> (sp_q == $past(usp_q)) && (ksp_q == $past(sp_q)));

  p_hold_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_i && !user_i |=> $stable(sp_q) && $stable(ksp_q));

  p_usp_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_i |=> $stable(usp_q));
endmodule

// File: rtl/rfe_store_chk.sv
module rfe_store_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_i,
  input  logic pend_i,
  output logic fail_o
);
  logic fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= chk_i & pend_i;
  end

  assign fail_o = fail_q;

  p_fail_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_i && pend_i |=> fail_q);

  p_fail_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_i |=> !fail_q);
endmodule

// File: rtl/rfe_status_unit.sv
module rfe_status_unit #(
  parameter int unsigned DATA_W = rfe_pkg::DEF_DATA_W,
  parameter int unsigned KEEP_W = rfe_pkg::DEF_KEEP_W,
  parameter int unsigned GAP_W  = rfe_pkg::DEF_GAP_W,
  parameter int unsigned SHIFT  = rfe_pkg::DEF_SHIFT,
  parameter int unsigned U_BIT  = rfe_pkg::DEF_U_BIT,
  parameter int unsigned P_BIT  = rfe_pkg::DEF_P_BIT,
  parameter int unsigned R_BIT  = rfe_pkg::DEF_R_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfe_i,
  input  logic              st_chk_i,
  input  logic              stat_we_i,
  input  logic [DATA_W-1:0] stat_wdata_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_wdata_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] usp_wdata_i,
  input  logic              ksp_we_i,
  input  logic [DATA_W-1:0] ksp_wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] ksp_o,
  output logic              st_fail_o
);
  localparam int unsigned LOW_W = DATA_W - KEEP_W - GAP_W;

  logic [DATA_W-1:0] stat_q, stat_next;
  logic              user_sel;

  rfe_shift #(
    .DATA_W(DATA_W), .KEEP_W(KEEP_W), .GAP_W(GAP_W), .SHIFT(SHIFT),
    .U_BIT(U_BIT), .P_BIT(P_BIT), .R_BIT(R_BIT)
  ) u_shift (
    .stat_i(stat_q), .stat_next_o(stat_next), .user_o(user_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         stat_q <= '0;
    else if (rfe_i)     stat_q <= stat_next;
    else if (stat_we_i) stat_q <= stat_wdata_i;
  end

  rfe_stack #(.DATA_W(DATA_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .rfe_i(rfe_i), .user_i(user_sel),
    .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
    .usp_we_i(usp_we_i), .usp_wdata_i(usp_wdata_i),
    .ksp_we_i(ksp_we_i), .ksp_wdata_i(ksp_wdata_i),
    .sp_o(sp_o), .ksp_o(ksp_o)
  );

  rfe_store_chk u_store (
    .clk(clk), .rst_n(rst_n), .chk_i(st_chk_i),
    .pend_i(stat_q[P_BIT]), .fail_o(st_fail_o)
  );

  assign stat_o = stat_q;

  p_keep_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_i |=> stat_q[DATA_W-1 -: KEEP_W] == $past(stat_q[DATA_W-1 -: KEEP_W]));

  p_gap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_i |=> stat_q[LOW_W+GAP_W-1 -: GAP_W] == '0);

  p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_i |=> (stat_q[R_BIT] || stat_q[P_BIT]));
endmodule

// File: tb/test_rfe_status_unit.sv
`timescale 1ns/1ps
module test_rfe_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rfe_i = 1'b0, st_chk_i = 1'b0;
  logic        stat_we_i = 1'b0, sp_we_i = 1'b0, usp_we_i = 1'b0, ksp_we_i = 1'b0;
  logic [31:0] stat_wdata_i = '0, sp_wdata_i = '0, usp_wdata_i = '0, ksp_wdata_i = '0;
  logic [31:0] stat_o, sp_o, ksp_o;
  logic        st_fail_o;

  always #2 clk = ~clk;

  rfe_status_unit i_rfe_status_unit (
    .clk(clk), .rst_n(rst_n), .rfe_i(rfe_i), .st_chk_i(st_chk_i),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i),
    .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
    .usp_we_i(usp_we_i), .usp_wdata_i(usp_wdata_i),
    .ksp_we_i(ksp_we_i), .ksp_wdata_i(ksp_wdata_i),
    .stat_o(stat_o), .sp_o(sp_o), .ksp_o(ksp_o), .st_fail_o(st_fail_o)
  );

  typedef struct {
    logic [31:0] stat, sp, ksp;
    logic        fail;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_fail = 0;
  logic done = 1'b0;
  logic [31:0] m_stat = '0, m_sp = '0, m_usp = '0, m_ksp = '0;

  task automatic op(input logic rfe, input logic chk,
                    input logic swe, input logic [31:0] sd,
                    input logic pwe, input logic [31:0] pd,
                    input logic uwe, input logic [31:0] ud,
                    input logic kwe, input logic [31:0] kd,
                    input string req);
    exp_t e;
    logic [31:0] sh;
    @(negedge clk);
    rfe_i = rfe; st_chk_i = chk;
    stat_we_i = swe; stat_wdata_i = sd;
    sp_we_i = pwe; sp_wdata_i = pd;
    usp_we_i = uwe; usp_wdata_i = ud;
    ksp_we_i = kwe; ksp_wdata_i = kd;
    e.fail = chk && m_stat[7];
    if (rfe) begin
      sh = {m_stat[31:30], 2'b00, 10'b0, m_stat[27:10]};
      if (sh[8]) begin m_ksp = m_sp; m_sp = m_usp; end
      if (!sh[9]) sh[7] = 1'b1;
      m_stat = sh;
    end else begin
      if (swe) m_stat = sd;
      if (pwe) m_sp = pd;
      if (uwe) m_usp = ud;
      if (kwe) m_ksp = kd;
    end
    e.stat = m_stat; e.sp = m_sp; e.ksp = m_ksp; e.req = req;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_run++;
      if (stat_o !== e.stat || sp_o !== e.sp || ksp_o !== e.ksp || st_fail_o !== e.fail) begin
        n_fail++;
        $display("FAIL %s: got stat=%h sp=%h ksp=%h fail=%b exp stat=%h sp=%h ksp=%h fail=%b",
                 e.req, stat_o, sp_o, ksp_o, st_fail_o, e.stat, e.sp, e.ksp, e.fail);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (stat_o !== 0 || sp_o !== 0 || ksp_o !== 0 || st_fail_o !== 0) begin
      n_fail++;
      $display("FAIL R6 reset: got stat=%h sp=%h ksp=%h fail=%b exp all 0",
               stat_o, sp_o, ksp_o, st_fail_o);
    end
    rst_n = 1'b1;
    // R7: plain writes
    op(0,0, 1,32'hF004_0000, 1,32'h0000_1000, 1,32'h0000_2000, 1,32'h0000_3000, "R7 writes");
    // R1 R2 R4: shifted bit 8 set, bit 9 clear -> swap and P set
    op(1,0, 0,'0, 0,'0, 0,'0, 0,'0, "R1 R2 R4 return to user");
    // R5: P now 1 -> fail
    op(0,1, 0,'0, 0,'0, 0,'0, 0,'0, "R5 check with P set");
    op(0,0, 0,'0, 0,'0, 0,'0, 0,'0, "R5 idle after check");
    // R3 R4: R set in shifted value, U clear, P stays 0
    op(0,0, 1,32'h3008_0000, 1,32'h0000_4444, 1,32'h0000_5555, 0,'0, "R7 writes 2");
    op(1,0, 0,'0, 0,'0, 0,'0, 0,'0, "R1 R3 R4 return keeps kernel");
    op(0,1, 0,'0, 0,'0, 0,'0, 0,'0, "R5 check with P clear");
    // R1: high bits in shifted region dropped, top bits kept
    op(0,0, 1,32'h8FFF_FFFF, 0,'0, 0,'0, 0,'0, "R7 write all-ones field");
    op(1,0, 0,'0, 0,'0, 0,'0, 0,'0, "R1 R2 R4 return with R set");
    // R8: writes in a return cycle ignored
    op(0,0, 1,32'h4000_0000, 1,32'h0000_7000, 1,32'h0000_8000, 1,32'h0000_9000, "R7 writes 3");
    op(1,0, 1,32'hFFFF_FFFF, 1,32'h1111_1111, 1,32'h2222_2222, 1,32'h3333_3333, "R8 writes ignored");
    op(0,0, 0,'0, 0,'0, 0,'0, 0,'0, "R8 state after ignored writes");
    // R9: check in same cycle as return uses pre-return P
    op(0,0, 1,32'h0008_0080, 0,'0, 0,'0, 0,'0, "R7 set P with R in field");
    op(1,1, 0,'0, 0,'0, 0,'0, 0,'0, "R9 check uses old P=1");
    op(0,0, 1,32'h0000_0000, 0,'0, 0,'0, 0,'0, "R7 clear status");
    op(1,1, 0,'0, 0,'0, 0,'0, 0,'0, "R9 check uses old P=0");
    op(0,1, 0,'0, 0,'0, 0,'0, 0,'0, "R5 R9 check after return");
    op(0,0, 0,'0, 0,'0, 0,'0, 0,'0, "R5 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule